// File: doc/BRIEF.md
# Boot-Time Persistent DIMM Restore Sequencer

This block runs once memory training has finished. Every DIMM, persistent or not, has already been trained as a standard DIMM. A single start pulse makes the sequencer visit each DIMM slot in turn, lowest index first. For each slot it reads four status flags: save still running, image valid, error logged, and restore finished. From these it decides whether the slot's contents should be brought back from the DIMM's non-volatile store.

When a restore is called for, the sequencer holds the clock-enable line low and issues a one-cycle restore request. It then polls the slot until the slot reports completion or a bounded poll window expires. After that it brings the DIMM back into service in a fixed order: register-control rewrite while clock-enable is still low, then clock-enable high, then mode-register rewrite.

Each slot ends up with one of three result bits, or none of them: restored, error logged, or timed out. The memory-test mask marks every slot that was not restored, so that later firmware can test and initialise those slots.

Top module: `restore_sequencer`

## Requirements
- R1: After reset the sequencer is idle. `cke_o` is 1, `busy_o`, `done_o`, `restore_go_o`, `rc_wr_o` and `mrs_wr_o` are 0, all result bits are 0, and `test_mask_o` is all ones.
- R2: A `start_i` pulse while idle clears all results and visits the slots one at a time in increasing index, shown on `dimm_sel_o`. A one-cycle `done_o` follows the last slot, and `busy_o` is 1 from the cycle after start until the cycle after `done_o`. A `start_i` while busy is ignored.
- R3: While the selected slot's `save_busy_i` bit is 1, the sequencer takes no further step for that slot: it does not lower `cke_o`, request a restore or write any result.
- R4: A slot whose `img_valid_i` bit is 0 gets no commands and no result bit, and stays flagged in `test_mask_o`.
- R5: A slot with valid data and `err_logged_i` set gets `errlog_o` set for its index and no commands, and stays flagged in `test_mask_o`.
- R6: For a slot with valid data and no logged error, the sequencer drives these steps in order, each in its own cycle: `cke_o` falls; a one-cycle `restore_go_o`; polling; a one-cycle `rc_wr_o` with `cke_o` still 0; `cke_o` rises; a one-cycle `mrs_wr_o` with `cke_o` at 1.
- R7: Let `POLL_LIMIT` be the poll window. The slot is restored if its `restore_done_i` bit rises no more than `POLL_LIMIT` cycles after the cycle in which `restore_go_o` was seen. Otherwise `timeout_o` is set for that slot. In both cases the rewrite steps of R6 still follow.
- R8: Each slot takes at most one result bit per run. `test_mask_o` bit i is 1 exactly when `restored_o` bit i is 0.
- R9: `NUM_DIMMS` is 1 to 8, `IDX_W` is wide enough to index every slot, and `POLL_LIMIT` is at least 1. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| save_busy_i | input | NUM_DIMMS | Per slot: a save is still in progress |
| img_valid_i | input | NUM_DIMMS | Per slot: the stored image is valid |
| err_logged_i | input | NUM_DIMMS | Per slot: the DIMM logged an error |
| restore_done_i | input | NUM_DIMMS | Per slot: the restore has completed |
| dimm_sel_o | output | IDX_W | Index of the slot being handled |
| cke_o | output | 1 | Clock-enable level for the selected slot |
| restore_go_o | output | 1 | One-cycle restore request |
| rc_wr_o | output | 1 | One-cycle register-control rewrite strobe |
| mrs_wr_o | output | 1 | One-cycle mode-register rewrite strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| restored_o | output | NUM_DIMMS | Per slot: restore completed |
| errlog_o | output | NUM_DIMMS | Per slot: logged error recorded |
| timeout_o | output | NUM_DIMMS | Per slot: poll window expired |
| test_mask_o | output | NUM_DIMMS | Per slot: needs memory test and initialisation |

## Verification
The hardest case to reach from the ports is the edge of the poll window. The outcome flips between restored and timed out when completion arrives in exactly the last poll cycle rather than one cycle later. The bench therefore answers each restore request with a completion delay measured from the cycle where the request is seen, and directed runs use delays of exactly `POLL_LIMIT` and `POLL_LIMIT+1`. Random runs add long save-busy holds on later slots, so that a wait begins only after earlier slots have already gone through their rewrite sequence.

// File: rtl/restore_seq_pkg.sv
package restore_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SAVE_WAIT,
      ST_VALID,
      ST_ERRCHK,
      ST_CKE_LOW,
      ST_GO,
      ST_POLL,
      ST_RC,
      ST_CKE_UP,
      ST_MRS,
      ST_NEXT,
      ST_DONE
   } seq_state_e;

   typedef enum logic [1:0] {
      RES_NONE,
      RES_RESTORED,
      RES_ERRLOG,
      RES_TIMEOUT
   } res_kind_e;

   typedef struct packed {
      logic save_busy;
      logic img_valid;
      logic err_log;
      logic rst_done;
   } dimm_stat_t;

endpackage

// File: rtl/dimm_stat_mux.sv
module dimm_stat_mux
   import restore_seq_pkg::*;
#(
   parameter int NUM_DIMMS = 4,
   parameter int IDX_W     = 2
) (
   input  logic [NUM_DIMMS-1:0] save_busy_i,
   input  logic [NUM_DIMMS-1:0] img_valid_i,
   input  logic [NUM_DIMMS-1:0] err_logged_i,
   input  logic [NUM_DIMMS-1:0] restore_done_i,
   input  logic [IDX_W-1:0]     idx_i,
   output dimm_stat_t           stat_o
);

   generate
      if (NUM_DIMMS == 1) begin : g_single
         logic unused_idx;
         assign unused_idx = ^idx_i;
         assign stat_o = '{save_busy: save_busy_i[0],
                           img_valid: img_valid_i[0],
                           err_log:   err_logged_i[0],
                           rst_done:  restore_done_i[0]};
      end else begin : g_multi
         always_comb begin
            stat_o = '0;
            for (int k = 0; k < NUM_DIMMS; k++) begin
               if (idx_i == IDX_W'(k)) begin
                  stat_o = '{save_busy: save_busy_i[k],
                             img_valid: img_valid_i[k],
                             err_log:   err_logged_i[k],
                             rst_done:  restore_done_i[k]};
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic expired_o
);

   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         cnt_q <= '0;
      end else if (run_i && cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = run_i && (cnt_q == LAST);

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clear_i && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/restore_results.sv
module restore_results
   import restore_seq_pkg::*;
#(
   parameter int NUM_DIMMS = 4,
   parameter int IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_i,
   input  logic                 wr_i,
   input  logic [IDX_W-1:0]     idx_i,
   input  res_kind_e            kind_i,
   output logic [NUM_DIMMS-1:0] restored_o,
   output logic [NUM_DIMMS-1:0] errlog_o,
   output logic [NUM_DIMMS-1:0] timeout_o,
   output logic [NUM_DIMMS-1:0] test_mask_o
);

   generate
      for (genvar i = 0; i < NUM_DIMMS; i++) begin : g_slot
         logic hit;
         assign hit = wr_i && (idx_i == IDX_W'(i));

         always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
               restored_o[i] <= 1'b0;
               errlog_o[i]   <= 1'b0;
               timeout_o[i]  <= 1'b0;
            end else if (hit) begin
               restored_o[i] <= (kind_i == RES_RESTORED);
               errlog_o[i]   <= (kind_i == RES_ERRLOG);
               timeout_o[i]  <= (kind_i == RES_TIMEOUT);
            end
         end

         assign test_mask_o[i] = ~restored_o[i];

         assert_write_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !clear_i) |-> !(restored_o[i] || errlog_o[i] || timeout_o[i]));
      end
   endgenerate

endmodule

// File: rtl/restore_sequencer.sv
module restore_sequencer
   import restore_seq_pkg::*;
#(
   parameter int NUM_DIMMS  = 4,
   parameter int IDX_W      = (NUM_DIMMS > 1) ? $clog2(NUM_DIMMS) : 1,
   parameter int POLL_LIMIT = 1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [NUM_DIMMS-1:0] save_busy_i,
   input  logic [NUM_DIMMS-1:0] img_valid_i,
   input  logic [NUM_DIMMS-1:0] err_logged_i,
   input  logic [NUM_DIMMS-1:0] restore_done_i,
   output logic [IDX_W-1:0]     dimm_sel_o,
   output logic                 cke_o,
   output logic                 restore_go_o,
   output logic                 rc_wr_o,
   output logic                 mrs_wr_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [NUM_DIMMS-1:0] restored_o,
   output logic [NUM_DIMMS-1:0] errlog_o,
   output logic [NUM_DIMMS-1:0] timeout_o,
   output logic [NUM_DIMMS-1:0] test_mask_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIMMS - 1);

   initial begin
      assert_param_count_R9: assert (NUM_DIMMS >= 1 && NUM_DIMMS <= 8)
         else $error("NUM_DIMMS out of range");
      assert_param_idx_R9: assert ((1 << IDX_W) >= NUM_DIMMS)
         else $error("IDX_W too narrow");
      assert_param_poll_R9: assert (POLL_LIMIT >= 1)
         else $error("POLL_LIMIT must be positive");
   end

   seq_state_e        state_q, state_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   dimm_stat_t        stat;
   logic              expired;
   logic              res_clear, res_wr;
   res_kind_e         res_kind;

   dimm_stat_mux #(.NUM_DIMMS(NUM_DIMMS), .IDX_W(IDX_W)) i_mux (
      .save_busy_i   (save_busy_i),
      .img_valid_i   (img_valid_i),
      .err_logged_i  (err_logged_i),
      .restore_done_i(restore_done_i),
      .idx_i         (idx_q),
      .stat_o        (stat)
   );

   poll_timer #(.LIMIT(POLL_LIMIT)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (state_q == ST_GO),
      .run_i    (state_q == ST_POLL),
      .expired_o(expired)
   );

   restore_results #(.NUM_DIMMS(NUM_DIMMS), .IDX_W(IDX_W)) i_results (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (res_clear),
      .wr_i       (res_wr),
      .idx_i      (idx_q),
      .kind_i     (res_kind),
      .restored_o (restored_o),
      .errlog_o   (errlog_o),
      .timeout_o  (timeout_o),
      .test_mask_o(test_mask_o)
   );

   always_comb begin
      state_d   = state_q;
      idx_d     = idx_q;
      res_clear = 1'b0;
      res_wr    = 1'b0;
      res_kind  = RES_NONE;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               res_clear = 1'b1;
               idx_d     = '0;
               state_d   = ST_SAVE_WAIT;
            end
         end
         ST_SAVE_WAIT: if (!stat.save_busy) state_d = ST_VALID;
         ST_VALID:     state_d = stat.img_valid ? ST_ERRCHK : ST_NEXT;
         ST_ERRCHK: begin
            if (stat.err_log) begin
               res_wr   = 1'b1;
               res_kind = RES_ERRLOG;
               state_d  = ST_NEXT;
            end else begin
               state_d  = ST_CKE_LOW;
            end
         end
         ST_CKE_LOW:   state_d = ST_GO;
         ST_GO:        state_d = ST_POLL;
         ST_POLL: begin
            if (stat.rst_done) begin
               res_wr   = 1'b1;
               res_kind = RES_RESTORED;
               state_d  = ST_RC;
            end else if (expired) begin
               res_wr   = 1'b1;
               res_kind = RES_TIMEOUT;
               state_d  = ST_RC;
            end
         end
         ST_RC:        state_d = ST_CKE_UP;
         ST_CKE_UP:    state_d = ST_MRS;
         ST_MRS:       state_d = ST_NEXT;
         ST_NEXT: begin
            if (idx_q == LAST_IDX) begin
               state_d = ST_DONE;
            end else begin
               idx_d   = idx_q + 1'b1;
               state_d = ST_SAVE_WAIT;
            end
         end
         ST_DONE:      state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
      end
   end

   assign dimm_sel_o   = idx_q;
   assign cke_o        = !(state_q inside {ST_CKE_LOW, ST_GO, ST_POLL, ST_RC});
   assign restore_go_o = (state_q == ST_GO);
   assign rc_wr_o      = (state_q == ST_RC);
   assign mrs_wr_o     = (state_q == ST_MRS);
   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = (state_q == ST_DONE);

   // R6: clock-enable rises only right after the register-control rewrite
   assert_cke_rise_after_rc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> $past(rc_wr_o));

   assert_mrs_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |=> mrs_wr_o);

   assert_go_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |=> restore_go_o);

   assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({restore_go_o, rc_wr_o, mrs_wr_o, done_o}));

   // R3, R4, R5: a restore is requested only for a settled, valid, error-free slot
   assert_go_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restore_go_o |-> (!stat.save_busy && stat.img_valid && !stat.err_log));

   assert_idx_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dimm_sel_o != $past(dimm_sel_o)) |-> (dimm_sel_o == $past(dimm_sel_o) + 1'b1 || dimm_sel_o == '0));

   assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

endmodule

// File: tb/test_restore_sequencer.sv
module test_restore_sequencer;

   localparam int N = 4;
   localparam int W = 2;
   localparam int L = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [N-1:0] save_busy_i = '0;
   logic [N-1:0] img_valid_i = '0;
   logic [N-1:0] err_logged_i = '0;
   logic [N-1:0] restore_done_i = '0;
   logic [W-1:0] dimm_sel_o;
   logic         cke_o, restore_go_o, rc_wr_o, mrs_wr_o, busy_o, done_o;
   logic [N-1:0] restored_o, errlog_o, timeout_o, test_mask_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   int sb[N];
   int dd[N];
   bit vv[N];
   bit ee[N];

   restore_sequencer #(.NUM_DIMMS(N), .IDX_W(W), .POLL_LIMIT(L)) i_restore_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .save_busy_i(save_busy_i), .img_valid_i(img_valid_i),
      .err_logged_i(err_logged_i), .restore_done_i(restore_done_i),
      .dimm_sel_o(dimm_sel_o), .cke_o(cke_o), .restore_go_o(restore_go_o),
      .rc_wr_o(rc_wr_o), .mrs_wr_o(mrs_wr_o), .busy_o(busy_o), .done_o(done_o),
      .restored_o(restored_o), .errlog_o(errlog_o), .timeout_o(timeout_o),
      .test_mask_o(test_mask_o)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic bit exp_seq(input int i);
      return vv[i] && !ee[i];
   endfunction

   function automatic bit exp_restored(input int i);
      return exp_seq(i) && (dd[i] <= L);
   endfunction

   task automatic run_once(input string tag);
      int  stage[N];
      int  cd[N];
      int  last_idx;
      int  dones;
      bit  prev_cke;
      bit  fin;
      for (int i = 0; i < N; i++) begin
         stage[i] = 0;
         cd[i] = -1;
         img_valid_i[i] = vv[i];
         err_logged_i[i] = ee[i];
         save_busy_i[i] = (sb[i] > 0);
      end
      restore_done_i = '0;
      last_idx = -1;
      dones = 0;
      prev_cke = 1'b1;
      fin = 1'b0;
      start_i = 1'b1;
      for (int t = 0; t < 4000 && !fin; t++) begin
         @(negedge clk);
         // observe
         if (prev_cke && !cke_o) begin
            chk("R2 slot order", 32'(int'(dimm_sel_o) > last_idx), 32'd1);
            last_idx = int'(dimm_sel_o);
            chk("R6 cke falls first", 32'(stage[dimm_sel_o]), 32'd0);
            chk("R3 save released before restore", 32'(save_busy_i[dimm_sel_o]), 32'd0);
            stage[dimm_sel_o] = 1;
         end
         if (restore_go_o) begin
            chk("R6 request after cke low", 32'(stage[dimm_sel_o]), 32'd1);
            stage[dimm_sel_o] = 2;
         end
         if (rc_wr_o) begin
            chk("R6 rc rewrite with cke low", {stage[dimm_sel_o][30:0], cke_o}, {31'd2, 1'b0});
            stage[dimm_sel_o] = 3;
         end
         if (!prev_cke && cke_o) begin
            chk("R6 cke rises after rc", 32'(stage[dimm_sel_o]), 32'd3);
            stage[dimm_sel_o] = 4;
         end
         if (mrs_wr_o) begin
            chk("R6 mrs rewrite with cke high", {stage[dimm_sel_o][30:0], cke_o}, {31'd4, 1'b1});
            stage[dimm_sel_o] = 5;
         end
         if (done_o) begin
            dones++;
            fin = 1'b1;
         end
         prev_cke = cke_o;
         // drive: R7 completion countdown counted in observed cycles
         for (int i = 0; i < N; i++) begin
            if (cd[i] > 0) begin
               cd[i]--;
               if (cd[i] == 0) restore_done_i[i] = 1'b1;
            end
         end
         if (restore_go_o) begin
            cd[dimm_sel_o] = dd[dimm_sel_o];
            if (dd[dimm_sel_o] == 0) restore_done_i[dimm_sel_o] = 1'b1;
         end
         for (int i = 0; i < N; i++) save_busy_i[i] = (t + 1 < sb[i]);
         start_i = (t == 4);   // R2: stray start while busy must be ignored
      end
      start_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (done_o) dones++;
      end
      chk({"R2 single done ", tag}, 32'(dones), 32'd1);
      chk({"R2 idle after done ", tag}, 32'(busy_o), 32'd0);
      for (int i = 0; i < N; i++) begin
         chk({"R4 R6 command sequence ", tag}, 32'(stage[i]), exp_seq(i) ? 32'd5 : 32'd0);
         chk({"R7 restored bit ", tag}, 32'(restored_o[i]), 32'(exp_restored(i)));
         chk({"R5 errlog bit ", tag}, 32'(errlog_o[i]), 32'(vv[i] && ee[i]));
         chk({"R7 timeout bit ", tag}, 32'(timeout_o[i]), 32'(exp_seq(i) && !exp_restored(i)));
         chk({"R8 test mask bit ", tag}, 32'(test_mask_o[i]), 32'(!exp_restored(i)));
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cke high", 32'(cke_o), 32'd1);
      chk("R1 idle", 32'({busy_o, done_o, restore_go_o, rc_wr_o, mrs_wr_o}), 32'd0);
      chk("R1 results clear", 32'({restored_o, errlog_o, timeout_o}), 32'd0);
      chk("R1 mask all ones", 32'(test_mask_o), 32'hF);

      // directed: poll window edges R7
      for (int i = 0; i < N; i++) begin vv[i] = 1; ee[i] = 0; sb[i] = 0; end
      dd[0] = 0; dd[1] = L; dd[2] = L + 1; dd[3] = 3;
      run_once("edges");
      // directed: invalid, error, long save wait, timeout R3 R4 R5
      vv[0] = 0; ee[0] = 0; sb[0] = 0;  dd[0] = 0;
      vv[1] = 1; ee[1] = 1; sb[1] = 0;  dd[1] = 0;
      vv[2] = 1; ee[2] = 0; sb[2] = 60; dd[2] = 2;
      vv[3] = 1; ee[3] = 0; sb[3] = 0;  dd[3] = L + 5;
      run_once("mixed");
      // directed: nothing valid, results from previous run cleared R8
      for (int i = 0; i < N; i++) begin vv[i] = 0; ee[i] = 1; sb[i] = 5; dd[i] = 0; end
      run_once("none");
      // constrained random
      for (int r = 0; r < 30; r++) begin
         for (int i = 0; i < N; i++) begin
            vv[i] = ($urandom % 4) != 0;
            ee[i] = ($urandom % 5) == 0;
            sb[i] = (($urandom % 3) == 0) ? int'($urandom % 40) : 0;
            dd[i] = int'($urandom % (L + 4));
         end
         run_once("random");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule